// File: doc/BRIEF.md
# Stage-Triggered Reset Pulse Sequencer

This block follows the boot-stage codes that a target processor reports while it starts up, and turns two chosen stages into a timed sequence. When the first chosen stage is seen, it requests that the target clock be slowed. When the second chosen stage begins, it counts a programmed delay. It then drives a single reset pulse of programmed width, waits a programmed hold time, and withdraws the slowdown request.

Stage progress is taken either from the full code bus or from one code bit whose accepted toggles are counted since arm. Every input passes a synchronizer and a stability filter. The delay count can advance on both clock edges, which doubles the resolution of the delay value. The slowdown is either a level output or a pair of one-cycle command requests aimed at an external serial command engine.

Each arm fires the sequence at most once. If the second stage never arrives, a timeout withdraws the slowdown and flags the run.

Top module: `stage_pulse_seq`

## Requirements
- R1: `arm` is accepted only in the idle or finished condition. In the cycle after acceptance `busy` is 1 and `done` and `timeout_flag` are 0. Every `cfg_*` value is captured at that edge, so later changes to the inputs do not affect the running sequence.
- R2: In code mode (`cfg_bit_mode`=0) the stage is the last stable value of `code_in`. A value that is applied just before rising edge E0 and first equals `cfg_slow_stage` while armed raises the slowdown at edge E0+4.
- R3: In bit mode (`cfg_bit_mode`=1) the stage is the number of accepted toggles of `code_bit` since arm. A new level is accepted only when it holds for two consecutive synchronized samples, so a toggle lasting one clock is ignored. An accepted toggle applied before E0 takes effect at E0+4.
- R4: When the stage first equals `cfg_cmp_stage` after the slowdown (stage value applied before E0), delay counting starts at E0+4. In coarse mode (`cfg_fine`=0) `rst_pulse` rises at edge E0+5+`cfg_delay`.
- R5: In fine mode (`cfg_fine`=1) the delay is counted in half clock periods, on both edges. `rst_pulse` rises at edge E0+4+ceil((`cfg_delay`+1)/2).
- R6: `rst_pulse` stays high for max(`cfg_width`,1) cycles. In level mode it is only high while `slow_level` is high.
- R7: After the pulse falls at edge F, the slowdown is withdrawn and `done` rises at edge F+`cfg_hold`+1. `busy` then returns to 0.
- R8: In serial mode (`cfg_serial`=1) `slow_level` stays 0. `slow_cmd_req` is a one-cycle pulse at the edge where level mode would raise the slowdown. `restore_cmd_req` is a one-cycle pulse at the edge where level mode would withdraw it.
- R9: If the compare stage is not seen, the slowdown is withdrawn at edge S+`cfg_timeout`+1, where S is the slowdown edge. At that edge `done` and `timeout_flag` both become 1 and no pulse is driven.
- R10: After `done`, stage changes cause no slowdown and no pulse. An `arm` during a running sequence is ignored.
- R11: While `rst` is high and after it is released, all outputs are 0 until an arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing reference clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start a sequence and capture configuration |
| code_in | input | CODE_W | Boot stage code bus (asynchronous) |
| code_bit | input | 1 | Single toggling stage bit (asynchronous) |
| cfg_bit_mode | input | 1 | 1: count toggles of code_bit; 0: use code_in |
| cfg_fine | input | 1 | 1: count delay on both clock edges |
| cfg_serial | input | 1 | 1: slowdown via command requests; 0: level output |
| cfg_slow_stage | input | CODE_W | Stage that triggers slowdown |
| cfg_cmp_stage | input | CODE_W | Stage that starts the delay count |
| cfg_delay | input | DLY_W | Delay from compare stage to pulse |
| cfg_width | input | WID_W | Pulse width in cycles (0 acts as 1) |
| cfg_hold | input | HOLD_W | Cycles between pulse end and release |
| cfg_timeout | input | TO_W | Wait limit for the compare stage |
| slow_level | output | 1 | Level slowdown request |
| slow_cmd_req | output | 1 | One-cycle request to send the slow command |
| restore_cmd_req | output | 1 | One-cycle request to send the restore command |
| rst_pulse | output | 1 | Reset pulse to the target |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished since last arm |
| timeout_flag | output | 1 | Finished because the compare stage was not seen |

## Verification
Stage inputs change just after a falling edge, so the first rising edge E0 that samples them is known. Every result then has a fixed edge: a slowdown or slow command at E0+4, a coarse pulse at E0+5+delay, a fine pulse at E0+4+ceil((delay+1)/2), pulse fall after the width, release one cycle past the hold or the timeout. Whenever the bench changes a stage it queues each output transition with its exact edge number. A monitor that samples on falling edges requires every observed transition to match the head of that queue in kind and in cycle. Any transition that nothing predicted, such as one caused by a one-cycle glitch or by stage changes after finish, is therefore caught the cycle it appears.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_ARMED,
    SEQ_SLOWED,
    SEQ_COUNTING,
    SEQ_PULSE,
    SEQ_HOLD,
    SEQ_DONE
  } seq_state_t;

endpackage

// File: rtl/sps_stage_tracker.sv
module sps_stage_tracker #(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_count,
  input  logic              bit_mode,
  input  logic [CODE_W-1:0] code_in,
  input  logic              code_bit,
  output logic [CODE_W-1:0] stage
);

  localparam int BUS_W = CODE_W + 1;
  localparam int LAST  = SYNC_STAGES - 1;

  logic [BUS_W-1:0]  sync_q [SYNC_STAGES];
  logic [BUS_W-1:0]  settle_q;
  logic [CODE_W-1:0] code_acc;
  logic              bit_acc;
  logic [CODE_W-1:0] toggle_cnt;

  logic              code_stable;
  logic              bit_stable;

  // a value counts as valid once two consecutive synchronized samples agree
  assign code_stable = (sync_q[LAST][CODE_W-1:0] == settle_q[CODE_W-1:0]);
  assign bit_stable  = (sync_q[LAST][CODE_W] == settle_q[CODE_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      settle_q <= '0;
    end else begin
      sync_q[0] <= {code_bit, code_in};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      settle_q <= sync_q[LAST];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_acc <= '0;
    end else if (code_stable) begin
      code_acc <= settle_q[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_acc    <= 1'b0;
      toggle_cnt <= '0;
    end else begin
      if (bit_stable && (settle_q[CODE_W] != bit_acc)) bit_acc <= settle_q[CODE_W];
      if (clr_count) begin
        toggle_cnt <= '0;
      end else if (bit_stable && (settle_q[CODE_W] != bit_acc)) begin
        toggle_cnt <= toggle_cnt + 1'b1;
      end
    end
  end

  assign stage = bit_mode ? toggle_cnt : code_acc;

endmodule

// File: rtl/sps_half_timer.sv
module sps_half_timer #(
  parameter int W            = 16,
  parameter bit DUAL_EDGE_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         fine,
  output logic [W:0]   elapsed
);

  logic [W-1:0] rise_cnt;
  logic [W-1:0] fall_cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) rise_cnt <= '0;
    else             rise_cnt <= rise_cnt + 1'b1;
  end

  generate
    if (DUAL_EDGE_EN) begin : g_dual
      // second counter on the opposite edge; the sum counts half periods
      always_ff @(negedge clk) begin
        if (rst || !run || !fine) fall_cnt <= '0;
        else                      fall_cnt <= fall_cnt + 1'b1;
      end
    end else begin : g_single
      assign fall_cnt = '0;
    end
  endgenerate

  assign elapsed = {1'b0, rise_cnt} + {1'b0, fall_cnt};

endmodule

// File: rtl/stage_pulse_seq.sv
module stage_pulse_seq
  import sps_pkg::*;
#(
  parameter int CODE_W       = 8,
  parameter int DLY_W        = 16,
  parameter int WID_W        = 8,
  parameter int HOLD_W       = 16,
  parameter int TO_W         = 24,
  parameter int SYNC_STAGES  = 2,
  parameter bit DUAL_EDGE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [CODE_W-1:0] code_in,
  input  logic              code_bit,
  input  logic              cfg_bit_mode,
  input  logic              cfg_fine,
  input  logic              cfg_serial,
  input  logic [CODE_W-1:0] cfg_slow_stage,
  input  logic [CODE_W-1:0] cfg_cmp_stage,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic [WID_W-1:0]  cfg_width,
  input  logic [HOLD_W-1:0] cfg_hold,
  input  logic [TO_W-1:0]   cfg_timeout,
  output logic              slow_level,
  output logic              slow_cmd_req,
  output logic              restore_cmd_req,
  output logic              rst_pulse,
  output logic              busy,
  output logic              done,
  output logic              timeout_flag
);

  typedef struct packed {
    logic              bit_mode;
    logic              fine;
    logic              serial;
    logic [CODE_W-1:0] slow_stage;
    logic [CODE_W-1:0] cmp_stage;
    logic [DLY_W-1:0]  delay;
    logic [WID_W-1:0]  width;
    logic [HOLD_W-1:0] hold;
    logic [TO_W-1:0]   timeout;
  } seq_cfg_t;

  seq_state_t        state;
  seq_cfg_t          cfg_q;
  logic              arm_ok;
  logic [CODE_W-1:0] stage;
  logic [DLY_W:0]    elapsed;
  logic              timer_run;
  logic [TO_W-1:0]   wait_cnt;
  logic [WID_W-1:0]  width_cnt;
  logic [HOLD_W-1:0] hold_cnt;
  logic              serial_q;

  assign arm_ok    = arm && ((state == SEQ_IDLE) || (state == SEQ_DONE));
  assign timer_run = (state == SEQ_COUNTING);
  assign serial_q  = cfg_q.serial;

  sps_stage_tracker #(
    .CODE_W     (CODE_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_tracker (
    .clk      (clk),
    .rst      (rst),
    .clr_count(arm_ok),
    .bit_mode (cfg_q.bit_mode),
    .code_in  (code_in),
    .code_bit (code_bit),
    .stage    (stage)
  );

  sps_half_timer #(
    .W           (DLY_W),
    .DUAL_EDGE_EN(DUAL_EDGE_EN)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (timer_run),
    .fine   (cfg_q.fine),
    .elapsed(elapsed)
  );

  always_ff @(posedge clk) begin
    slow_cmd_req    <= 1'b0;
    restore_cmd_req <= 1'b0;
    if (rst) begin
      state        <= SEQ_IDLE;
      cfg_q        <= '0;
      slow_level   <= 1'b0;
      rst_pulse    <= 1'b0;
      busy         <= 1'b0;
      done         <= 1'b0;
      timeout_flag <= 1'b0;
      wait_cnt     <= '0;
      width_cnt    <= '0;
      hold_cnt     <= '0;
    end else begin
      case (state)
        SEQ_IDLE, SEQ_DONE: begin
          if (arm) begin
            state        <= SEQ_ARMED;
            cfg_q        <= '{bit_mode: cfg_bit_mode, fine: cfg_fine, serial: cfg_serial,
                              slow_stage: cfg_slow_stage, cmp_stage: cfg_cmp_stage,
                              delay: cfg_delay, width: cfg_width, hold: cfg_hold,
                              timeout: cfg_timeout};
            busy         <= 1'b1;
            done         <= 1'b0;
            timeout_flag <= 1'b0;
          end
        end
        SEQ_ARMED: begin
          if (stage == cfg_q.slow_stage) begin
            state    <= SEQ_SLOWED;
            wait_cnt <= cfg_q.timeout;
            if (cfg_q.serial) slow_cmd_req <= 1'b1;
            else              slow_level   <= 1'b1;
          end
        end
        SEQ_SLOWED: begin
          if (stage == cfg_q.cmp_stage) begin
            state <= SEQ_COUNTING;
          end else if (wait_cnt == '0) begin
            state        <= SEQ_DONE;
            slow_level   <= 1'b0;
            busy         <= 1'b0;
            done         <= 1'b1;
            timeout_flag <= 1'b1;
            if (cfg_q.serial) restore_cmd_req <= 1'b1;
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        SEQ_COUNTING: begin
          if (elapsed >= {1'b0, cfg_q.delay}) begin
            state     <= SEQ_PULSE;
            rst_pulse <= 1'b1;
            width_cnt <= (cfg_q.width == '0) ? '0 : cfg_q.width - 1'b1;
          end
        end
        SEQ_PULSE: begin
          if (width_cnt == '0) begin
            state     <= SEQ_HOLD;
            rst_pulse <= 1'b0;
            hold_cnt  <= cfg_q.hold;
          end else begin
            width_cnt <= width_cnt - 1'b1;
          end
        end
        SEQ_HOLD: begin
          if (hold_cnt == '0) begin
            state      <= SEQ_DONE;
            slow_level <= 1'b0;
            busy       <= 1'b0;
            done       <= 1'b1;
            if (cfg_q.serial) restore_cmd_req <= 1'b1;
          end else begin
            hold_cnt <= hold_cnt - 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sps_checker.sv
module sps_checker (
  input logic clk,
  input logic rst,
  input logic slow_level,
  input logic slow_cmd_req,
  input logic restore_cmd_req,
  input logic rst_pulse,
  input logic busy,
  input logic done,
  input logic timeout_flag,
  input logic serial_q
);

  assert_busy_done_excl_R1: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  assert_pulse_under_slow_R6: assert property (@(posedge clk) disable iff (rst)
    (rst_pulse && !serial_q) |-> slow_level);

  assert_release_sets_done_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(slow_level) |-> done);

  assert_slow_req_single_R8: assert property (@(posedge clk) disable iff (rst)
    slow_cmd_req |=> !slow_cmd_req);

  assert_restore_req_single_R8: assert property (@(posedge clk) disable iff (rst)
    restore_cmd_req |=> !restore_cmd_req);

  assert_serial_no_level_R8: assert property (@(posedge clk) disable iff (rst)
    (serial_q && busy) |-> !slow_level);

  assert_timeout_implies_done_R9: assert property (@(posedge clk) disable iff (rst)
    timeout_flag |-> done);

  assert_quiet_after_done_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!rst_pulse && !slow_level));

endmodule

bind stage_pulse_seq sps_checker u_sps_checker (
  .clk            (clk),
  .rst            (rst),
  .slow_level     (slow_level),
  .slow_cmd_req   (slow_cmd_req),
  .restore_cmd_req(restore_cmd_req),
  .rst_pulse      (rst_pulse),
  .busy           (busy),
  .done           (done),
  .timeout_flag   (timeout_flag),
  .serial_q       (serial_q)
);

// File: tb/stage_pulse_seq_bench.sv
module stage_pulse_seq_bench;

  localparam int CODE_W = 8;
  localparam int DLY_W  = 16;
  localparam int WID_W  = 8;
  localparam int HOLD_W = 16;
  localparam int TO_W   = 24;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              arm = 1'b0;
  logic [CODE_W-1:0] code_in = '0;
  logic              code_bit = 1'b0;
  logic              cfg_bit_mode = 1'b0;
  logic              cfg_fine = 1'b0;
  logic              cfg_serial = 1'b0;
  logic [CODE_W-1:0] cfg_slow_stage = 8'h36;
  logic [CODE_W-1:0] cfg_cmp_stage = 8'h39;
  logic [DLY_W-1:0]  cfg_delay = '0;
  logic [WID_W-1:0]  cfg_width = '0;
  logic [HOLD_W-1:0] cfg_hold = '0;
  logic [TO_W-1:0]   cfg_timeout = '0;
  logic slow_level, slow_cmd_req, restore_cmd_req, rst_pulse, busy, done, timeout_flag;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit finished = 1'b0;

  // expected event queues: kind, edge number, requirement tag
  int    exp_kind[$];
  int    exp_cyc[$];
  string exp_req[$];
  string kind_name [6] = '{"SLOW_ON", "CMD_SLOW", "PULSE_ON", "PULSE_OFF", "SLOW_OFF", "CMD_RESTORE"};

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stage_pulse_seq u_stage_pulse_seq (
    .clk(clk), .rst(rst), .arm(arm), .code_in(code_in), .code_bit(code_bit),
    .cfg_bit_mode(cfg_bit_mode), .cfg_fine(cfg_fine), .cfg_serial(cfg_serial),
    .cfg_slow_stage(cfg_slow_stage), .cfg_cmp_stage(cfg_cmp_stage),
    .cfg_delay(cfg_delay), .cfg_width(cfg_width), .cfg_hold(cfg_hold),
    .cfg_timeout(cfg_timeout), .slow_level(slow_level), .slow_cmd_req(slow_cmd_req),
    .restore_cmd_req(restore_cmd_req), .rst_pulse(rst_pulse), .busy(busy),
    .done(done), .timeout_flag(timeout_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_ev(input int kind, input int at, input string req);
    exp_kind.push_back(kind);
    exp_cyc.push_back(at);
    exp_req.push_back(req);
  endtask

  function automatic void observe(input int kind);
    n_tests++;
    if (exp_kind.size() == 0) begin
      n_fail++;
      $display("[TB] FAIL unexpected %s at cycle %0d, actual=%0d expected=none (R10)",
               kind_name[kind], cyc, kind);
    end else begin
      int    k = exp_kind.pop_front();
      int    c = exp_cyc.pop_front();
      string r = exp_req.pop_front();
      if (k != kind || c != cyc) begin
        n_fail++;
        $display("[TB] FAIL %s actual=%s@%0d expected=%s@%0d", r, kind_name[kind], cyc,
                 kind_name[k], c);
      end
    end
  endfunction

  // monitor: samples away from the rising edge
  logic prev_slow  = 1'b0;
  logic prev_pulse = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (slow_level && !prev_slow)  observe(0);
      if (slow_cmd_req)              observe(1);
      if (rst_pulse && !prev_pulse)  observe(2);
      if (!rst_pulse && prev_pulse)  observe(3);
      if (!slow_level && prev_slow)  observe(4);
      if (restore_cmd_req)           observe(5);
    end
    prev_slow  = slow_level;
    prev_pulse = rst_pulse;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // change the code bus just after a falling edge; return the sampling edge
  task automatic drive_code(input logic [CODE_W-1:0] v, output int e0);
    @(negedge clk);
    code_in = v;
    e0 = cyc + 1;
  endtask

  task automatic drive_bit(input logic v, output int e0);
    @(negedge clk);
    code_bit = v;
    e0 = cyc + 1;
  endtask

  task automatic do_arm();
    @(negedge clk);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic drain(input string req);
    int guard = 0;
    while (exp_kind.size() != 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    tick(2);
    check(exp_kind.size() == 0, req, exp_kind.size(), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("[TB] FAIL watchdog expired (R1) actual=%0d expected=0", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    int e0, e1, p;
    tick(4);
    // R11: reset state
    check({slow_level, slow_cmd_req, restore_cmd_req, rst_pulse, busy, done, timeout_flag} == '0,
          "R11 outputs during reset", {slow_level, rst_pulse, busy, done}, 0);
    @(negedge clk);
    rst = 1'b0;
    tick(3);
    check({slow_level, slow_cmd_req, restore_cmd_req, rst_pulse, busy, done, timeout_flag} == '0,
          "R11 outputs after reset", {slow_level, rst_pulse, busy, done}, 0);

    // ---- coarse, code bus, level slowdown ----
    cfg_delay = 16'd10; cfg_width = 8'd3; cfg_hold = 16'd5; cfg_timeout = 24'd1000;
    do_arm();
    check(busy == 1'b1, "R1 busy after arm", busy, 1);
    check(done == 1'b0, "R1 done clear after arm", done, 0);
    cfg_delay = 16'd200;   // R1: must not affect the running sequence
    cfg_width = 8'd50;
    drive_code(8'h36, e0);
    expect_ev(0, e0 + 4, "R2 slowdown on code");
    tick(6);
    drive_code(8'h37, e0);
    tick(3);
    drive_code(8'h39, e1);
    p = e1 + 5 + 10;
    expect_ev(2, p, "R4 coarse pulse start");
    expect_ev(3, p + 3, "R6 pulse width 3");
    expect_ev(4, p + 3 + 5 + 1, "R7 release after hold");
    tick(2);
    do_arm();              // R10: ignored while busy
    drain("R4 coarse sequence complete");
    check(done == 1'b1, "R7 done after release", done, 1);
    check(busy == 1'b0, "R7 busy cleared", busy, 0);
    check(timeout_flag == 1'b0, "R7 no timeout", timeout_flag, 0);

    // R10: after done, stage changes do nothing
    drive_code(8'h36, e0);
    tick(6);
    drive_code(8'h39, e0);
    tick(40);
    check(rst_pulse == 1'b0 && done == 1'b1, "R10 no action after done", rst_pulse, 0);

    // ---- fine mode, width 0 acts as 1, hold 0 ----
    drive_code(8'h00, e0);
    tick(6);
    cfg_fine = 1'b1; cfg_delay = 16'd7; cfg_width = 8'd0; cfg_hold = 16'd0;
    do_arm();
    drive_code(8'h36, e0);
    expect_ev(0, e0 + 4, "R2 slowdown fine run");
    tick(6);
    drive_code(8'h39, e1);
    p = e1 + 4 + 4;
    expect_ev(2, p, "R5 fine pulse delay 7");
    expect_ev(3, p + 1, "R6 width 0 acts as 1");
    expect_ev(4, p + 2, "R7 release hold 0");
    drain("R5 fine sequence complete");

    // ---- fine mode, delay 4 ----
    drive_code(8'h00, e0);
    tick(6);
    cfg_delay = 16'd4; cfg_width = 8'd2; cfg_hold = 16'd1;
    do_arm();
    drive_code(8'h36, e0);
    expect_ev(0, e0 + 4, "R2 slowdown fine run 2");
    tick(5);
    drive_code(8'h39, e1);
    p = e1 + 4 + 3;
    expect_ev(2, p, "R5 fine pulse delay 4");
    expect_ev(3, p + 2, "R6 width 2");
    expect_ev(4, p + 2 + 2, "R7 release hold 1");
    drain("R5 fine sequence 2 complete");

    // ---- timeout ----
    drive_code(8'h00, e0);
    tick(6);
    cfg_fine = 1'b0; cfg_timeout = 24'd20;
    do_arm();
    drive_code(8'h36, e0);
    expect_ev(0, e0 + 4, "R2 slowdown before timeout");
    expect_ev(4, e0 + 4 + 21, "R9 timeout release");
    drain("R9 timeout complete");
    check(timeout_flag == 1'b1, "R9 timeout flag", timeout_flag, 1);
    check(done == 1'b1, "R9 done on timeout", done, 1);

    // ---- bit mode, serial commands ----
    drive_code(8'h00, e0);
    cfg_bit_mode = 1'b1; cfg_serial = 1'b1; cfg_fine = 1'b0;
    cfg_slow_stage = 8'd2; cfg_cmp_stage = 8'd3;
    cfg_delay = 16'd0; cfg_width = 8'd2; cfg_hold = 16'd3; cfg_timeout = 24'd1000;
    do_arm();
    check(timeout_flag == 1'b0, "R1 timeout cleared on arm", timeout_flag, 0);
    drive_bit(1'b1, e0);   // R3: one-cycle glitch must be ignored
    drive_bit(1'b0, e0);
    tick(6);
    drive_bit(1'b1, e0);
    tick(5);
    drive_bit(1'b0, e0);
    expect_ev(1, e0 + 4, "R3 second toggle gives slow command");
    tick(6);
    drive_bit(1'b1, e1);
    p = e1 + 5;
    expect_ev(2, p, "R4 bit mode pulse delay 0");
    expect_ev(3, p + 2, "R6 bit mode width 2");
    expect_ev(5, p + 2 + 4, "R8 restore command");
    drain("R8 serial sequence complete");
    check(slow_level == 1'b0 && done == 1'b1, "R8 level stays low in serial mode", slow_level, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule